// File: doc/BRIEF.md
# Coarse Quarter/Eighth-Rate Frequency Shifter

This block moves a two-channel sample stream up or down in frequency by a fixed amount: one quarter or one eighth of the sample rate. It does not use a general oscillator. It steps through a short sequence of rotations. Each step is made of sign changes and channel swaps. On the odd steps of the eighth-rate sequence there is also one constant multiply by 0.70711.

The two input channels can be handled in two ways:
- **Complex mode:** the channels form one complex signal, with channel A as the in-phase part and channel B as the quadrature part. The block rotates this signal in the chosen direction.
- **Real mode:** each channel is mixed with the cosine of the chosen rate on its own. In this mode the direction setting has no effect.

Samples enter with a valid strobe. Each result is registered and appears one cycle later.

The rotation phase counts only valid samples. It restarts whenever the shift mode changes. Every result is saturated to the input width.

Top module: `fs_shift_mixer`

## Requirements
- R1: With mode_i = 00 or 11 the block passes through: one cycle after a valid sample, ch_a_o = ch_a_i and ch_b_o = ch_b_i.
- R2: After reset, valid_o = 0 and both outputs are 0. valid_o is high exactly one cycle after valid_i. The outputs hold their value in every cycle that follows a cycle without valid_i.
- R3: With mode_i = 01, real_i = 0 and neg_i = 0, the valid sample at phase k (0..3) gives (A,B) → (A,B), (-B,A), (-A,-B), (B,-A) for k = 0, 1, 2, 3. This is a multiply by j^k.
- R4: With mode_i = 01, real_i = 0 and neg_i = 1, the phases give (A,B), (B,-A), (-A,-B), (-B,A). This is a multiply by (-j)^k.
- R5: With mode_i = 10 and real_i = 0, phase k runs from 0 to 7.
  - An even k applies the quarter-rate rotation of step k/2 in the selected direction.
  - An odd k first forms (s(A-B), s(A+B)) when neg_i = 0, or (s(A+B), s(B-A)) when neg_i = 1. It then applies the rotation of step (k-1)/2 in the same direction.
  - s(x) = (x·23170 + 16384) >>> 15, an arithmetic shift.
- R6: With real_i = 1, each channel is multiplied by a cosine sequence, and neg_i has no effect.
  - Mode 01 uses 1, 0, -1, 0.
  - Mode 10 uses 1, s, 0, -s, -1, -s, 0, s. Here ±s means ±s(x).
- R7: The phase advances by one only on a valid sample. It wraps at 4 in mode 01 and at 8 in mode 10. After reset the first valid sample uses phase 0.
- R8: A change of mode_i returns the phase to 0, whether or not a sample is valid in that cycle. The first valid sample under the new mode uses phase 0. A change of neg_i or real_i does not reset the phase.
- R9: Results outside [-2^(DATA_W-1), 2^(DATA_W-1)-1] are clamped to the nearer limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| mode_i | input | 2 | Shift mode: 00 or 11 bypass, 01 quarter rate, 10 eighth rate |
| neg_i | input | 1 | 1 selects a negative shift (complex mode only) |
| real_i | input | 1 | 1 selects an independent real mix per channel |
| ch_a_i | input | DATA_W | Channel A sample (in-phase), two's complement |
| ch_b_i | input | DATA_W | Channel B sample (quadrature), two's complement |
| valid_o | output | 1 | Output sample strobe |
| ch_a_o | output | DATA_W | Shifted channel A |
| ch_b_o | output | DATA_W | Shifted channel B |

## Verification
The bench uses several input patterns, each chosen to tell apart a specific kind of fault:
- **Constant pair with unequal channels, stepped through every quarter-rate phase in both directions:** shows which channel is swapped and which sign is flipped at each step. A mirrored or mis-ordered rotation fails at least one phase.
- **Eighth-rate sequences with mixed-sign values, run with both neg_i settings:** exercise the scaled odd phases and their rounding. Both real-mode runs must give the same output, which shows that the direction input really is ignored in real mode.
- **Full-scale negative values:** drive the negation and sum paths into saturation.
- **Idle gaps and a mode change while idle:** separate "the phase advances only on valid samples" from "the phase restarts on a mode change".

// File: rtl/fsmix_pkg.sv
package fsmix_pkg;
  typedef enum logic [1:0] {
    MODE_BYP = 2'b00,
    MODE_QTR = 2'b01,
    MODE_OCT = 2'b10,
    MODE_RSV = 2'b11
  } shift_mode_e;

  localparam int unsigned PH_W = 3;
endpackage

// File: rtl/fsmix_phase.sv
module fsmix_phase
  import fsmix_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      mode_i,
  output logic [PH_W-1:0] phase_o
);
  logic [1:0]      mode_q;
  logic [PH_W-1:0] phase_q, phase_eff, phase_d;

  // a mode change restarts the sequence in the same cycle
  assign phase_eff = (mode_i != mode_q) ? '0 : phase_q;
  assign phase_o   = phase_eff;

  always_comb begin
    phase_d = phase_eff;
    case (shift_mode_e'(mode_i))
      MODE_QTR: if (valid_i) phase_d = {1'b0, phase_eff[1:0] + 2'd1};
      MODE_OCT: if (valid_i) phase_d = phase_eff + 3'd1;
      default:  phase_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_BYP;
      phase_q <= '0;
    end else begin
      mode_q  <= mode_i;
      phase_q <= phase_d;
    end
  end

  assert_qtr_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_QTR) |-> !phase_q[2]);

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && mode_i == mode_q) |=> $stable(phase_q));

  assert_restart_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && mode_i != mode_q) |=> phase_q == '0);

  assert_restart_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != mode_q && (mode_i == MODE_QTR || mode_i == MODE_OCT))
    |=> phase_q == 3'd1);
endmodule

// File: rtl/fsmix_c45.sv
module fsmix_c45 #(
  parameter int unsigned IN_W   = 17,
  parameter int unsigned COEF_W = 16
) (
  input  logic signed [IN_W-1:0] x_i,
  output logic signed [IN_W-1:0] y_o
);
  localparam int unsigned SH = COEF_W - 1;
  localparam int unsigned PW = IN_W + COEF_W;
  localparam logic signed [COEF_W-1:0] C45 =
    COEF_W'(int'(0.7071067811865476 * (2.0 ** SH)));
  localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);

  logic signed [PW-1:0] prod, rnd;

  assign prod = PW'(x_i) * PW'(C45);
  assign rnd  = prod + HALF;
  // |x * 0.707| stays inside IN_W bits
  assign y_o  = IN_W'(rnd >>> SH);
endmodule

// File: rtl/fsmix_rot.sv
module fsmix_rot
  import fsmix_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic [PH_W-1:0]          phase_i,
  input  logic [1:0]               mode_i,
  input  logic                     neg_i,
  input  logic                     real_i,
  output logic signed [DATA_W-1:0] a_o,
  output logic signed [DATA_W-1:0] b_o
);
  localparam int unsigned SW = DATA_W + 1;
  localparam int unsigned RW = DATA_W + 2;
  localparam logic signed [RW-1:0] MAXV = {3'b000, {(DATA_W-1){1'b1}}};
  localparam logic signed [RW-1:0] MINV = {3'b111, {(DATA_W-1){1'b0}}};

  logic signed [SW-1:0] ae, be, sum_ab, dif_ab, dif_ba;
  logic signed [SW-1:0] op [2];
  logic signed [SW-1:0] sc [2];
  logic signed [RW-1:0] p0, p1, r0, r1;
  logic                 active, odd;
  logic [1:0]           q, qd;

  assign ae     = SW'(a_i);
  assign be     = SW'(b_i);
  assign sum_ab = ae + be;
  assign dif_ab = ae - be;
  assign dif_ba = be - ae;

  assign active = (mode_i == MODE_QTR) || (mode_i == MODE_OCT);
  assign odd    = (mode_i == MODE_OCT) && phase_i[0];
  assign q      = (mode_i == MODE_OCT) ? phase_i[2:1] : phase_i[1:0];
  assign qd     = neg_i ? 2'(2'd0 - q) : q;

  // 45-degree pre-step operands; real mode scales each channel alone
  always_comb begin
    op[0] = real_i ? ae : (neg_i ? sum_ab : dif_ab);
    op[1] = real_i ? be : (neg_i ? dif_ba : sum_ab);
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    fsmix_c45 #(.IN_W(SW), .COEF_W(COEF_W)) u_c45 (
      .x_i(op[g]),
      .y_o(sc[g])
    );
  end

  assign p0 = RW'(odd ? sc[0] : ae);
  assign p1 = RW'(odd ? sc[1] : be);

  always_comb begin
    r0 = p0;
    r1 = p1;
    if (!active) begin
      r0 = RW'(ae);
      r1 = RW'(be);
    end else if (real_i) begin
      if (odd) begin
        if (q == 2'd1 || q == 2'd2) begin
          r0 = -p0;
          r1 = -p1;
        end
      end else begin
        case (q)
          2'd0:    ;
          2'd2:    begin r0 = -p0; r1 = -p1; end
          default: begin r0 = '0;  r1 = '0;  end
        endcase
      end
    end else begin
      case (qd)
        2'd0: begin r0 = p0;  r1 = p1;  end
        2'd1: begin r0 = -p1; r1 = p0;  end
        2'd2: begin r0 = -p0; r1 = -p1; end
        2'd3: begin r0 = p1;  r1 = -p0; end
      endcase
    end
  end

  function automatic logic signed [DATA_W-1:0] sat(input logic signed [RW-1:0] v);
    logic signed [RW-1:0] c;
    c = (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
    return DATA_W'(c);
  endfunction

  assign a_o = sat(r0);
  assign b_o = sat(r1);
endmodule

// File: rtl/fs_shift_mixer.sv
module fs_shift_mixer
  import fsmix_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [1:0]               mode_i,
  input  logic                     neg_i,
  input  logic                     real_i,
  input  logic signed [DATA_W-1:0] ch_a_i,
  input  logic signed [DATA_W-1:0] ch_b_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] ch_a_o,
  output logic signed [DATA_W-1:0] ch_b_o
);
  logic [PH_W-1:0]          phase_used;
  logic signed [DATA_W-1:0] mix_a, mix_b;

  fsmix_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .mode_i (mode_i),
    .phase_o(phase_used)
  );

  fsmix_rot #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_rot (
    .a_i    (ch_a_i),
    .b_i    (ch_b_i),
    .phase_i(phase_used),
    .mode_i (mode_i),
    .neg_i  (neg_i),
    .real_i (real_i),
    .a_o    (mix_a),
    .b_o    (mix_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_a_o  <= '0;
      ch_b_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ch_a_o <= mix_a;
        ch_b_o <= mix_b;
      end
    end
  end

  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mode_i) == MODE_BYP || $past(mode_i) == MODE_RSV))
    |-> (ch_a_o == $past(ch_a_i) && ch_b_o == $past(ch_b_i)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(ch_a_o) && $stable(ch_b_o) && !valid_o));

  assert_real_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(real_i && mode_i == MODE_QTR && phase_used[0]))
    |-> (ch_a_o == '0 && ch_b_o == '0));
endmodule

// File: tb/fs_shift_mixer_tb_top.sv
module fs_shift_mixer_tb_top;
  localparam int W = 16;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                valid_i = 1'b0;
  logic [1:0]          mode_i = 2'b00;
  logic                neg_i = 1'b0;
  logic                real_i = 1'b0;
  logic signed [W-1:0] ch_a_i = '0;
  logic signed [W-1:0] ch_b_i = '0;
  logic                valid_o;
  logic signed [W-1:0] ch_a_o, ch_b_o;

  int         checks = 0;
  int         fails = 0;
  int         ph = 0;
  logic [1:0] last_mode = 2'b00;
  bit         done = 0;

  fs_shift_mixer #(.DATA_W(W), .COEF_W(16)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .neg_i(neg_i), .real_i(real_i), .ch_a_i(ch_a_i), .ch_b_i(ch_b_i),
    .valid_o(valid_o), .ch_a_o(ch_a_o), .ch_b_o(ch_b_o)
  );

  always #5 clk_i = ~clk_i;

  // mode(2) neg real a(16) b(16) exp_a(16) exp_b(16)
  localparam logic [67:0] VEC [10] = '{
    {2'b00, 1'b0, 1'b0, 16'sd100,  -16'sd200, 16'sd100,   -16'sd200},
    {2'b01, 1'b0, 1'b0, 16'sd1000, 16'sd300,  16'sd1000,  16'sd300},
    {2'b01, 1'b0, 1'b0, 16'sd1000, 16'sd300,  -16'sd300,  16'sd1000},
    {2'b01, 1'b0, 1'b0, 16'sd1000, 16'sd300,  -16'sd1000, -16'sd300},
    {2'b01, 1'b0, 1'b0, 16'sd1000, 16'sd300,  16'sd300,   -16'sd1000},
    {2'b01, 1'b0, 1'b0, 16'sd5,    16'sd7,    16'sd5,     16'sd7},
    {2'b01, 1'b1, 1'b0, 16'sd5,    16'sd7,    16'sd7,     -16'sd5},
    {2'b10, 1'b0, 1'b0, 16'sd1000, 16'sd0,    16'sd1000,  16'sd0},
    {2'b10, 1'b0, 1'b0, 16'sd1000, 16'sd0,    16'sd707,   16'sd707},
    {2'b10, 1'b0, 1'b0, 16'sd1000, 16'sd0,    16'sd0,     16'sd1000}
  };

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic longint s45(input longint x);
    return (x * 23170 + 16384) >>> 15;
  endfunction

  task automatic take_phase(input logic [1:0] m, output int k);
    if (m != last_mode) ph = 0;
    k = ph;
    if (m == 2'b01)      ph = (ph + 1) % 4;
    else if (m == 2'b10) ph = (ph + 1) % 8;
    else                 ph = 0;
    last_mode = m;
  endtask

  task automatic model(input logic [1:0] m, input logic n, input logic r,
                       input int a, input int b, input int k,
                       output int ea, output int eb);
    longint p0, p1, x0, x1;
    int q, qd;
    bit odd;
    if (m == 2'b00 || m == 2'b11) begin
      ea = a; eb = b;
      return;
    end
    odd = (m == 2'b10) && (k % 2 == 1);
    q = (m == 2'b10) ? k / 2 : k;
    if (r) begin
      if (!odd) begin
        p0 = (q == 0) ? a : (q == 2) ? -a : 0;
        p1 = (q == 0) ? b : (q == 2) ? -b : 0;
      end else begin
        p0 = (q == 0 || q == 3) ? s45(a) : -s45(a);
        p1 = (q == 0 || q == 3) ? s45(b) : -s45(b);
      end
    end else begin
      if (odd) begin
        x0 = n ? s45(a + b) : s45(a - b);
        x1 = n ? s45(b - a) : s45(a + b);
      end else begin
        x0 = a; x1 = b;
      end
      qd = n ? (4 - q) % 4 : q;
      case (qd)
        0:       begin p0 = x0;  p1 = x1;  end
        1:       begin p0 = -x1; p1 = x0;  end
        2:       begin p0 = -x0; p1 = -x1; end
        default: begin p0 = x1;  p1 = -x0; end
      endcase
    end
    ea = sat(p0);
    eb = sat(p1);
  endtask

  // caller stands at a negedge; returns at the next negedge with valid_i low
  task automatic drive_chk(input logic [1:0] m, input logic n, input logic r,
                           input int a, input int b, input int ea, input int eb,
                           input string tag);
    int k;
    take_phase(m, k);
    mode_i = m; neg_i = n; real_i = r;
    ch_a_i = W'(a); ch_b_i = W'(b); valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1 || ch_a_o !== W'(ea) || ch_b_o !== W'(eb)) begin
      fails++;
      $display("FAIL %s phase=%0d: got v=%0b a=%0d b=%0d, expected v=1 a=%0d b=%0d",
               tag, k, valid_o, ch_a_o, ch_b_o, ea, eb);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic n, input logic r,
                      input int a, input int b, input string tag);
    int k, ea, eb;
    k = (m != last_mode) ? 0 : ph;
    model(m, n, r, a, b, k, ea, eb);
    drive_chk(m, n, r, a, b, ea, eb, tag);
  endtask

  initial begin
    int va [8] = '{1000, -2500, 32767, -32768, 123, -7, 20000, -19999};
    int vb [8] = '{-300, 4000, -32768, 32767, -456, 9, -15000, 1};
    logic signed [W-1:0] hold_a, hold_b;

    repeat (3) @(negedge clk_i);
    checks++;  // R2 reset state
    if (valid_o !== 1'b0 || ch_a_o !== '0 || ch_b_o !== '0) begin
      fails++;
      $display("FAIL R2 reset: got v=%0b a=%0d b=%0d, expected v=0 a=0 b=0",
               valid_o, ch_a_o, ch_b_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3 R4 R5 vector table
    for (int i = 0; i < 10; i++) begin
      drive_chk(VEC[i][67:66], VEC[i][65], VEC[i][64],
                int'($signed(VEC[i][63:48])), int'($signed(VEC[i][47:32])),
                int'($signed(VEC[i][31:16])), int'($signed(VEC[i][15:0])),
                (VEC[i][67:66] == 2'b00) ? "R1" :
                (VEC[i][67:66] == 2'b10) ? "R5" : (VEC[i][65] ? "R4" : "R3"));
    end

    // R5 eighth-rate complex, both directions over full cycles
    for (int i = 0; i < 8; i++) send(2'b10, 1'b1, 1'b0, va[i], vb[i], "R5");
    for (int i = 0; i < 8; i++) send(2'b10, 1'b0, 1'b0, va[i], vb[i], "R5");

    // R4 quarter-rate negative over a full cycle (mode change also restarts phase, R8)
    for (int i = 0; i < 4; i++) send(2'b01, 1'b1, 1'b0, va[i], vb[i], "R4");

    // R9 saturation on negation and on the scaled sum
    send(2'b01, 1'b0, 1'b0, -32768, -32768, "R9");
    send(2'b01, 1'b0, 1'b0, -32768, 5, "R9");
    drive_chk(2'b01, 1'b0, 1'b0, -32768, -32768, 32767, 32767, "R9");
    send(2'b10, 1'b0, 1'b0, 0, 0, "R9");
    drive_chk(2'b10, 1'b0, 1'b0, -32768, 32767, -32768, -1, "R9");

    // R6 real mix, eighth rate: neg_i must make no difference
    for (int i = 0; i < 8; i++) send(2'b10, 1'b0, 1'b1, va[i], vb[i], "R6");
    for (int i = 0; i < 8; i++) send(2'b10, 1'b1, 1'b1, va[i], vb[i], "R6");
    // R6 real mix, quarter rate
    for (int i = 0; i < 4; i++) send(2'b01, 1'b1, 1'b1, va[i], vb[i], "R6");

    // R7 R2 idle gap: outputs hold, phase does not advance
    send(2'b01, 1'b0, 1'b0, 1000, 300, "R7");
    hold_a = ch_a_o; hold_b = ch_b_o;
    for (int i = 0; i < 4; i++) begin
      ch_a_i = W'(i * 77); ch_b_i = W'(-i);
      @(negedge clk_i);
      checks++;
      if (valid_o !== 1'b0 || ch_a_o !== hold_a || ch_b_o !== hold_b) begin
        fails++;
        $display("FAIL R2 idle hold: got v=%0b a=%0d b=%0d, expected v=0 a=%0d b=%0d",
                 valid_o, ch_a_o, ch_b_o, hold_a, hold_b);
      end
    end
    send(2'b01, 1'b0, 1'b0, 1000, 300, "R7");

    // R8 mode change while idle restarts the phase
    send(2'b10, 1'b0, 1'b0, 1000, 300, "R8");
    send(2'b10, 1'b0, 1'b0, 1000, 300, "R8");
    mode_i = 2'b01;
    repeat (2) @(negedge clk_i);
    last_mode = 2'b01; ph = 0;
    mode_i = 2'b10;
    drive_chk(2'b10, 1'b0, 1'b0, 1000, 300, 1000, 300, "R8");

    // R1 reserved code also passes through
    send(2'b11, 1'b1, 1'b1, -1234, 5678, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule